// File: doc/BRIEF.md
# RGB LED Matrix Scan Driver

This block refreshes a 64-column by 32-row RGB LED panel. The panel is split into an upper half and a lower half, each with 16 rows. The driver works on row pairs: row r of the upper half together with row r of the lower half. For each row pair it clocks 64 columns out on six single-bit colour lines, three for each half. It then blanks the panel, moves the row select, pulses the latch and turns the outputs back on. While that row pair is lit, the next one is shifted in.

Pixel data comes from an on-chip frame store that holds two buffers. The panel always shows the front buffer. The write port always lands in the back buffer. A swap request is remembered and carried out at the next frame boundary. Panel-clock timing is set by a parameter giving the half period in system clocks, so the panel clock can be held at or below its 25 MHz limit.

Top module: `led_scan_driver`

## Requirements
- R1: While reset is asserted, shift_clk and latch_stb are 0, out_en_n is 1, and row_sel and color are 0.
- R2: The panel clock is high for exactly HALF system cycles and low for exactly HALF cycles between consecutive rising edges within a row. Each row pair gets exactly COLS rising edges.
- R3: color changes only while shift_clk is low, and it is stable for at least HALF cycles before each rising edge of shift_clk. color bit 0/1/2 is red/green/blue of the upper half, and bit 3/4/5 is red/green/blue of the lower half.
- R4: latch_stb rises only after the COLS-th rising panel-clock edge of the row. It is high for exactly HALF cycles, and during that time shift_clk is 0 and out_en_n is 1.
- R5: row_sel changes only while out_en_n has been 1 for at least one cycle. Latched row pairs follow the order 0, 1, …, ROW_PAIRS-1 and then wrap to 0.
- R6: out_en_n stays 1 from reset until the first latch. It goes to 0 in the cycle latch_stb falls.
- R7: Writes go only to the back buffer. Data shown on the panel never reflects writes made since the last swap.
- R8: A swap request takes effect at the first row pair 0 that is shifted after the latch of row pair ROW_PAIRS-1. Every row pair of that frame comes from the new front buffer.
- R9: Several swap requests within one frame cause only one buffer exchange.
- R10: Write address is {row pair, column}, with the column in the low bits. The k-th bit shifted on colour line l after the latch of the previous row equals bit l of the word at column k. Column 0 is shifted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the back buffer |
| wr_addr | input | 10 | {row pair[3:0], column[5:0]} |
| wr_data | input | 6 | Pixel word, bit order as color |
| swap_req | input | 1 | One-cycle request to exchange buffers at frame end |
| shift_clk | output | 1 | Panel shift clock; data sampled on its rising edge |
| latch_stb | output | 1 | Latch pulse; rising edge transfers the shifted row |
| out_en_n | output | 1 | Active-low LED output enable |
| row_sel | output | 4 | Row-pair select |
| color | output | 6 | Serial colour data, upper RGB in bits 2:0, lower RGB in bits 5:3 |

## Verification
A corrupted column counter or read address shows up at the next latch. That latch then arrives after the wrong number of panel-clock edges, or carries shifted data that disagrees with the bench's copy of the buffer row, within one row time of about 260 cycles. A front-buffer select that flips at the wrong moment, flips twice, or never flips is caught at the first row pair latched after the frame boundary. An output enable or row select that moves out of order is caught in the cycle it moves.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  // Six serial colour lines: {B,G,R} lower half, {B,G,R} upper half.
  localparam int LINES = 6;

  typedef enum logic [1:0] {ST_SHIFT, ST_BLANK, ST_LATCH} scan_st_e;

  // The write port always targets the buffer not on display.
  function automatic logic write_side(input logic front);
    return ~front;
  endfunction
endpackage

// File: rtl/led_frame_store.sv
module led_frame_store #(
  parameter int AW = 11,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/led_buf_swap.sv
module led_buf_swap (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic frame_wrap,
  output logic front
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      front <= 1'b0;
    end else if (frame_wrap && pend) begin
      front <= ~front;
      pend  <= swap_req;
    end else if (swap_req) begin
      pend <= 1'b1;
    end
  end

  // R9: a request not consumed by a frame wrap stays pending
  p_req_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(swap_req) && !$past(frame_wrap)) |-> pend);
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int COLS      = 64,
  parameter int ROW_PAIRS = 16,
  parameter int HALF      = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINES-1:0]             rd_data,
  output logic [$clog2(ROW_PAIRS)-1:0] rd_row,
  output logic [$clog2(COLS)-1:0]      rd_col,
  output logic                         frame_wrap,
  output logic                         shift_clk,
  output logic                         latch_stb,
  output logic                         out_en_n,
  output logic [$clog2(ROW_PAIRS)-1:0] row_sel,
  output logic [LINES-1:0]             color
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROW_PAIRS);
  localparam int PW = (HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam logic [PW-1:0] PH_RISE = PW'(HALF);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * HALF - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROW_PAIRS - 1);

  function automatic logic [RW-1:0] next_row(input logic [RW-1:0] r);
    return (r == ROW_LAST) ? '0 : r + 1'b1;
  endfunction

  scan_st_e          st;
  logic [PW-1:0]     ph;
  logic [CW-1:0]     col;
  logic [RW-1:0]     row_ld;
  logic              sclk_q, lat_q, oen_q;
  logic [RW-1:0]     row_q;
  logic [LINES-1:0]  color_q;

  // Named events for assertions and the swap controller
  logic latch_done;
  assign latch_done = (st == ST_LATCH) && (ph == PH_RISE);
  assign frame_wrap = latch_done && (row_ld == ROW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_SHIFT;
      ph      <= '0;
      col     <= '0;
      row_ld  <= '0;
      sclk_q  <= 1'b0;
      lat_q   <= 1'b0;
      oen_q   <= 1'b1;
      row_q   <= '0;
      color_q <= '0;
    end else begin
      unique case (st)
        ST_SHIFT: begin
          if (ph == '0) begin
            color_q <= rd_data;
            sclk_q  <= 1'b0;
          end
          if (ph == PH_RISE) sclk_q <= 1'b1;
          if (ph == PH_LAST) begin
            ph <= '0;
            if (col == COL_LAST) begin
              col <= '0;
              st  <= ST_BLANK;
            end else begin
              col <= col + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_BLANK: begin
          if (ph == '0) begin
            sclk_q <= 1'b0;
            oen_q  <= 1'b1;
            ph     <= PW'(1);
          end else begin
            row_q <= row_ld;
            ph    <= '0;
            st    <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          if (ph == '0) lat_q <= 1'b1;
          if (latch_done) begin
            lat_q  <= 1'b0;
            oen_q  <= 1'b0;
            st     <= ST_SHIFT;
            ph     <= '0;
            row_ld <= next_row(row_ld);
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= ST_SHIFT;
      endcase
    end
  end

  assign rd_row    = row_ld;
  assign rd_col    = col;
  assign shift_clk = sclk_q;
  assign latch_stb = lat_q;
  assign out_en_n  = oen_q;
  assign row_sel   = row_q;
  assign color     = color_q;

  // Checker state: panel-clock rises since last latch, latch seen
  logic          sclk_d, seen_lat;
  logic [CW:0]   rise_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      seen_lat <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (lat_q) seen_lat <= 1'b1;
      if (lat_q) rise_cnt <= '0;
      else if (sclk_q && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(color_q));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(color_q));
  p_rise_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> (rise_cnt == (CW+1)'(COLS)));
  p_latch_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |-> (oen_q && !sclk_q));
  p_row_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_q) |-> (oen_q && $past(oen_q)));
  p_dark_until_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_lat |-> oen_q);
endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver
  import led_scan_pkg::*;
#(
  parameter int COLS      = 64,
  parameter int ROW_PAIRS = 16,
  parameter int HALF      = 2
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [$clog2(ROW_PAIRS)+$clog2(COLS)-1:0]     wr_addr,
  input  logic [5:0]                                    wr_data,
  input  logic                                          swap_req,
  output logic                                          shift_clk,
  output logic                                          latch_stb,
  output logic                                          out_en_n,
  output logic [$clog2(ROW_PAIRS)-1:0]                  row_sel,
  output logic [5:0]                                    color
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROW_PAIRS);
  localparam int AW = 1 + RW + CW;

  logic          front, frame_wrap;
  logic [RW-1:0] rd_row;
  logic [CW-1:0] rd_col;
  logic [LINES-1:0] rd_data;

  led_frame_store #(.AW(AW), .DW(LINES)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({write_side(front), wr_addr}),
    .wdata (wr_data),
    .raddr ({front, rd_row, rd_col}),
    .rdata (rd_data)
  );

  led_buf_swap u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_req   (swap_req),
    .frame_wrap (frame_wrap),
    .front      (front)
  );

  led_scan_seq #(.COLS(COLS), .ROW_PAIRS(ROW_PAIRS), .HALF(HALF)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .rd_row     (rd_row),
    .rd_col     (rd_col),
    .frame_wrap (frame_wrap),
    .shift_clk  (shift_clk),
    .latch_stb  (latch_stb),
    .out_en_n   (out_en_n),
    .row_sel    (row_sel),
    .color      (color)
  );

  // R8: the displayed buffer changes only while the last row pair is latched
  p_swap_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(front) |-> (row_sel == RW'(ROW_PAIRS - 1)));
endmodule

// File: tb/test_led_scan_driver.sv
module test_led_scan_driver;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 64;
  localparam int ROWS = 16;
  localparam int HALF = 2;
  localparam int WORDS = COLS * ROWS;
  localparam int WD_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic       swap_req = 1'b0;
  logic       shift_clk, latch_stb, out_en_n;
  logic [3:0] row_sel;
  logic [5:0] color;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_scan_driver #(.COLS(COLS), .ROW_PAIRS(ROWS), .HALF(HALF)) i_led_scan_driver (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .swap_req(swap_req), .shift_clk(shift_clk), .latch_stb(latch_stb),
    .out_en_n(out_en_n), .row_sel(row_sel), .color(color)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of both buffers; written only by the driver process
  logic [5:0] eb [0:1][0:WORDS-1];
  int req_tick = 0;   // driver side
  // monitor side
  int efront = 0, seen_tick = 0, n_latch = 0, n_flip = 0, last_row = 0;
  bit bpend = 0, armed = 0, seen_lat = 0;
  logic [COLS-1:0] cap [0:5];
  int rises, hi_len, lo_len, lat_len, since;
  logic prev_sclk, prev_lat, prev_oen;
  logic [3:0] prev_row;
  logic [5:0] prev_color;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Line l of row pair r from buffer b, column 0 in bit 0 (R10 / R3 bit order)
  function automatic logic [COLS-1:0] exp_line(input int b, input int r, input int l);
    logic [COLS-1:0] v;
    for (int k = 0; k < COLS; k++) v[k] = eb[b][r*COLS + k][l];
    return v;
  endfunction

  function automatic int row_after(input int r);
    return (r + 1) % ROWS;
  endfunction

  // Port monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0; hi_len = 0; lo_len = 0; lat_len = 0; since = 0;
      prev_sclk = 0; prev_lat = 0; prev_oen = 1; prev_row = 0; prev_color = 0;
      seen_lat = 0;
    end else if (!done) begin
      if (req_tick != seen_tick) begin seen_tick = req_tick; bpend = 1; end
      if (color != prev_color) since = 1; else since++;
      if (!seen_lat) chk(out_en_n == 1'b1, "R6 dark before first latch", 64'(out_en_n), 64'd1);
      // panel clock rising edge
      if (shift_clk && !prev_sclk) begin
        chk(since > HALF, "R3 setup before rise", 64'(since), 64'(HALF + 1));
        if (rises > 0) chk(lo_len == HALF, "R2 low time", 64'(lo_len), 64'(HALF));
        if (rises < COLS) for (int l = 0; l < 6; l++) cap[l][rises] = color[l];
        rises++;
        lo_len = 0;
      end
      if (shift_clk) hi_len++;
      else begin
        lo_len++;
        if (prev_sclk) begin
          chk(hi_len == HALF, "R2 high time", 64'(hi_len), 64'(HALF));
          hi_len = 0;
        end
      end
      if (color != prev_color)
        chk(shift_clk == 1'b0, "R3 color moves only with clock low", 64'(shift_clk), 64'd0);
      if (row_sel != prev_row)
        chk(out_en_n && prev_oen, "R5 row moves while dark", {62'd0, out_en_n, prev_oen}, 64'd3);
      // latch rising edge
      if (latch_stb && !prev_lat) begin
        chk(rises == COLS, "R2 R4 edges before latch", 64'(rises), 64'(COLS));
        chk(out_en_n && !shift_clk, "R4 dark during latch", {62'd0, out_en_n, shift_clk}, 64'd2);
        chk(row_sel == 4'(seen_lat ? row_after(last_row) : 0), "R5 row order",
            64'(row_sel), 64'(seen_lat ? row_after(last_row) : 0));
        if (armed)
          for (int l = 0; l < 6; l++)
            chk(cap[l] == exp_line(efront, int'(row_sel), l), "R7 R8 R10 row data",
                cap[l], exp_line(efront, int'(row_sel), l));
        if (row_sel == 4'(ROWS - 1) && bpend) begin
          efront ^= 1; bpend = 0; armed = 1; n_flip++;
        end
        last_row = int'(row_sel);
        seen_lat = 1;
        n_latch++;
        rises = 0;
        lat_len = 0;
      end
      if (latch_stb) lat_len++;
      else if (prev_lat) begin
        chk(lat_len == HALF, "R4 latch width", 64'(lat_len), 64'(HALF));
        chk(out_en_n == 1'b0, "R6 lit after latch", 64'(out_en_n), 64'd0);
      end
      prev_sclk = shift_clk; prev_lat = latch_stb; prev_oen = out_en_n;
      prev_row = row_sel; prev_color = color;
    end
  end

  task automatic put(input int a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'(a); wr_data = d;
    eb[efront ^ 1][a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_latches(input int n);
    int s;
    s = n_latch;
    while (n_latch < s + n) @(negedge clk);
  endtask

  task automatic request_swap();
    do wait_latches(1); while (!(last_row >= 2 && last_row <= 10));
    @(negedge clk); swap_req = 1'b1; req_tick++;
    @(negedge clk); swap_req = 1'b0;
  endtask

  task automatic wait_flip();
    int s;
    s = n_flip;
    while (n_flip == s) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    void'($urandom(32'd31337));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(shift_clk == 1'b0, "R1 clock idle", 64'(shift_clk), 64'd0);
    chk(latch_stb == 1'b0, "R1 latch idle", 64'(latch_stb), 64'd0);
    chk(out_en_n == 1'b1, "R1 outputs off", 64'(out_en_n), 64'd1);
    chk(row_sel == 4'd0, "R1 row zero", 64'(row_sel), 64'd0);
    chk(color == 6'd0, "R1 color zero", 64'(color), 64'd0);
    rst_n = 1'b1;

    // Fill buffer 1 (back) with random words, then show it
    for (int a = 0; a < WORDS; a++) put(a, 6'($urandom));
    request_swap();
    wait_flip();
    wait_latches(ROWS + 1);

    // Directed fill of buffer 0: row 0 all on, last row all off, edge columns marked
    for (int a = 0; a < WORDS; a++) begin
      logic [5:0] d;
      if (a < COLS) d = 6'h3F;
      else if (a >= WORDS - COLS) d = 6'h00;
      else if (a % COLS == 0) d = 6'h15;
      else if (a % COLS == COLS - 1) d = 6'h2A;
      else d = 6'($urandom);
      put(a, d);
    end
    // R9: two requests in one frame give one exchange
    request_swap();
    wait_latches(1);
    @(negedge clk); swap_req = 1'b1; req_tick++;
    @(negedge clk); swap_req = 1'b0;
    wait_flip();
    wait_latches(2 * ROWS + 2);

    // R7: random writes into the back buffer while the front is on display
    for (int round = 0; round < 3; round++) begin
      for (int i = 0; i < 300; i++) put(int'($urandom % WORDS), 6'($urandom));
      wait_latches(ROWS + 1);
      request_swap();
      wait_flip();
      wait_latches(ROWS + 1);
    end

    chk(n_flip == 5, "R8 R9 exchange count", 64'(n_flip), 64'd5);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual %0d expected <%0d cycles", WD_CYCLES, WD_CYCLES);
      summary();
      $finish;
    end
  end
endmodule